// File: doc/BRIEF.md
# Program-Flow Unit with Hardware Return Stack

This block decides where a 32-bit processor fetches next. On each cycle it receives one decoded instruction from the issue stage. The instruction carries an operation class, a 2-bit kind field, a condition-pass bit from the flag logic, an offset given as a direction bit plus a magnitude, one register operand and the current program counter. From these the block produces the next program counter as a combinational result.

Return addresses go onto a small on-chip LIFO and are not kept in a link register. Calls push onto it and returns pop from it. The same LIFO also serves explicit data-stack instructions, which can pop into a register, drop an entry, read the top entry without removing it, or push a register value.

Overflow and underflow raise error flags that stay set until reset. A stack access that fails leaves the stack as it was and keeps the program counter on the sequential path. None of these operations writes the status flags, so the block has no flag output. Condition evaluation and the interrupt controller sit outside this block.

Top module: `pcflow_unit`

## Requirements
- R1: After reset, `err_over` and `err_under` are low and the stack is empty, so a read of the top entry (class 11, kind 10) reports underflow and keeps `wb_en` low.
- R2: When `cond_ok` is low, `pc_next` equals `pc_cur + 4`. In that case `wb_en` and `irq_restore` are low and the stack is left unchanged, whatever the class and kind.
- R3: Class 01 with kind 00 is a relative jump. `pc_next` is `pc_cur + off_mag` when `off_neg` is 0 and `pc_cur - off_mag` when it is 1, both modulo 2^32.
- R4: Class 01 with kind 01 is a call. It pushes `pc_cur + 4` and sets `pc_next` to the relative target of R3.
- R5: Class 01 with kind 10 is a return and kind 11 is a return-from-interrupt. Both pop the top entry into `pc_next`. Only kind 11 drives `irq_restore` high, and only in that cycle.
- R6: Class 10 is a register-indirect jump and sets `pc_next` to `reg_val`. When kind bit 0 is 1, it first pushes `pc_cur` onto the stack.
- R7: Class 11 with kind 00 is a pop. It drives `wb_en` high and `wb_data` with the top entry, and removes that entry. `pc_next` is `pc_cur + 4`.
- R8: Class 11 with kind 01 is a discard. It removes the top entry and keeps `wb_en` low.
- R9: Class 11 with kind 10 is a fetch. It drives `wb_en` high and `wb_data` with the top entry, and leaves the stack depth unchanged.
- R10: Class 11 with kind 11 is a push. It places `reg_val` on top of the stack.
- R11: The stack holds DEPTH (default 8) entries and returns them in last-in, first-out order.
- R12: A push onto a full stack sets `err_over`. A pop, discard, fetch, return or return-from-interrupt on an empty stack sets `err_under`. In both cases the stack is unchanged, `pc_next` is `pc_cur + 4`, and `wb_en` and `irq_restore` stay low. Both flags stay set until reset.
- R13: Class 00 is a sequential instruction. `pc_next` is `pc_cur + 4` and the kind field has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_ok | input | 1 | The instruction's condition holds |
| op_cls | input | 2 | Class: 00 sequential, 01 relative, 10 indirect, 11 stack |
| op_kind | input | 2 | Kind field within the class |
| off_neg | input | 1 | Offset direction, 1 = backward |
| off_mag | input | 16 | Offset magnitude in bytes |
| reg_val | input | 32 | Register operand (indirect target or push data) |
| pc_cur | input | 32 | Program counter of this instruction |
| pc_next | output | 32 | Next program counter |
| wb_en | output | 1 | Register write-back valid |
| wb_data | output | 32 | Register write-back value |
| irq_restore | output | 1 | Re-enable interrupts (return-from-interrupt) |
| err_over | output | 1 | Sticky stack overflow error |
| err_under | output | 1 | Sticky stack underflow error |

## Verification
The hardest case to reach is an overflowing push. It needs a completely full stack, and after it the test must show that the stack was not corrupted. The stimulus pushes DEPTH distinct values and then one extra push. It then pops every entry back and compares each value in reverse order, which shows that the failed push neither overwrote the top entry nor moved the pointer. The empty-stack cases come from the same sequence: once the last entry is out, a pop, a return and a return-from-interrupt must each fall through to `pc_cur + 4` without a write-back or an interrupt re-enable.

// File: rtl/pcflow_pkg.sv
package pcflow_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ = 2'b00,
    CLS_REL = 2'b01,
    CLS_IND = 2'b10,
    CLS_STK = 2'b11
  } op_class_e;

  // relative-class kinds
  localparam logic [1:0] REL_JUMP = 2'b00;
  localparam logic [1:0] REL_CALL = 2'b01;
  localparam logic [1:0] REL_RET  = 2'b10;
  localparam logic [1:0] REL_RETI = 2'b11;

  // stack-class kinds
  localparam logic [1:0] STK_POP  = 2'b00;
  localparam logic [1:0] STK_DROP = 2'b01;
  localparam logic [1:0] STK_PEEK = 2'b10;
  localparam logic [1:0] STK_PUSH = 2'b11;

  typedef enum logic [1:0] {
    PC_SEQ = 2'b00,
    PC_REL = 2'b01,
    PC_REG = 2'b10,
    PC_TOP = 2'b11
  } pc_sel_e;

  typedef enum logic [1:0] {
    PS_LINK = 2'b00,  // pc + step
    PS_HERE = 2'b01,  // pc itself
    PS_REG  = 2'b10   // register operand
  } push_sel_e;

  typedef struct packed {
    logic      want_push;
    push_sel_e push_src;
    logic      want_pop;
    logic      want_top;
    logic      wb_req;
    pc_sel_e   pc_src;
    logic      reti;
  } flow_ctl_t;

endpackage

// File: rtl/pcflow_decode.sv
module pcflow_decode
  import pcflow_pkg::*;
(
  input  logic      cond_ok,
  input  op_class_e cls,
  input  logic [1:0] kind,
  input  logic      stk_full,
  input  logic      stk_empty,
  output logic      push_go,
  output push_sel_e push_src,
  output logic      pop_go,
  output logic      wb_en,
  output pc_sel_e   pc_src,
  output logic      irq_restore,
  output logic      over_evt,
  output logic      under_evt
);

  flow_ctl_t ctl;
  logic      fail;

  always_comb begin
    ctl = '{want_push: 1'b0, push_src: PS_LINK, want_pop: 1'b0,
            want_top: 1'b0, wb_req: 1'b0, pc_src: PC_SEQ, reti: 1'b0};
    if (cond_ok) begin
      unique case (cls)
        CLS_SEQ: ctl.pc_src = PC_SEQ;
        CLS_REL: begin
          unique case (kind)
            REL_JUMP: ctl.pc_src = PC_REL;
            REL_CALL: begin
              ctl.want_push = 1'b1;
              ctl.push_src  = PS_LINK;
              ctl.pc_src    = PC_REL;
            end
            default: begin  // return and return-from-interrupt
              ctl.want_top = 1'b1;
              ctl.want_pop = 1'b1;
              ctl.pc_src   = PC_TOP;
              ctl.reti     = (kind == REL_RETI);
            end
          endcase
        end
        CLS_IND: begin
          ctl.pc_src = PC_REG;
          if (kind[0]) begin
            ctl.want_push = 1'b1;
            ctl.push_src  = PS_HERE;
          end
        end
        CLS_STK: begin
          unique case (kind)
            STK_POP: begin
              ctl.want_top = 1'b1;
              ctl.want_pop = 1'b1;
              ctl.wb_req   = 1'b1;
            end
            STK_DROP: begin
              ctl.want_top = 1'b1;
              ctl.want_pop = 1'b1;
            end
            STK_PEEK: begin
              ctl.want_top = 1'b1;
              ctl.wb_req   = 1'b1;
            end
            default: begin
              ctl.want_push = 1'b1;
              ctl.push_src  = PS_REG;
            end
          endcase
        end
        default: ctl.pc_src = PC_SEQ;
      endcase
    end
  end

  // a failed stack access cancels the whole instruction's effect
  assign over_evt    = ctl.want_push & stk_full;
  assign under_evt   = ctl.want_top & stk_empty;
  assign fail        = over_evt | under_evt;
  assign push_go     = ctl.want_push & ~stk_full;
  assign pop_go      = ctl.want_pop & ~stk_empty;
  assign push_src    = ctl.push_src;
  assign wb_en       = ctl.wb_req & ~stk_empty;
  assign irq_restore = ctl.reti & ~stk_empty;
  assign pc_src      = fail ? PC_SEQ : ctl.pc_src;

endmodule

// File: rtl/pcflow_retstack.sv
module pcflow_retstack #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_go,
  input  logic                       pop_go,
  input  logic [W-1:0]               push_data,
  output logic [W-1:0]               top_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] depth
);

  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] count;
  logic [W-1:0]     mem [DEPTH];

  // one write port per slot: slot i takes data when it is the next free one
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_go && count == PTR_W'(i)) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (push_go) count <= count + 1'b1;
    else if (pop_go)  count <= count - 1'b1;
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == PTR_W'(i + 1)) top_data = mem[i];
    end
  end

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign depth = count;

endmodule

// File: rtl/pcflow_target.sv
module pcflow_target
  import pcflow_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 16,
  parameter int STEP  = 4
) (
  input  pc_sel_e        pc_src,
  input  logic [W-1:0]   pc_cur,
  input  logic           off_neg,
  input  logic [OFF_W-1:0] off_mag,
  input  logic [W-1:0]   reg_val,
  input  logic [W-1:0]   top_data,
  output logic [W-1:0]   link_pc,
  output logic [W-1:0]   pc_next
);

  function automatic logic [W-1:0] seq_pc(input logic [W-1:0] pc);
    return pc + W'(STEP);
  endfunction

  function automatic logic [W-1:0] rel_pc(input logic [W-1:0] pc,
                                          input logic neg,
                                          input logic [OFF_W-1:0] mag);
    logic [W-1:0] ext;
    ext = W'(mag);
    return neg ? (pc - ext) : (pc + ext);
  endfunction

  assign link_pc = seq_pc(pc_cur);

  always_comb begin
    unique case (pc_src)
      PC_REL:  pc_next = rel_pc(pc_cur, off_neg, off_mag);
      PC_REG:  pc_next = reg_val;
      PC_TOP:  pc_next = top_data;
      default: pc_next = link_pc;
    endcase
  end

endmodule

// File: rtl/pcflow_unit.sv
module pcflow_unit
  import pcflow_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 16,
  parameter int DEPTH = 8,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_ok,
  input  logic [1:0]       op_cls,
  input  logic [1:0]       op_kind,
  input  logic             off_neg,
  input  logic [OFF_W-1:0] off_mag,
  input  logic [W-1:0]     reg_val,
  input  logic [W-1:0]     pc_cur,
  output logic [W-1:0]     pc_next,
  output logic             wb_en,
  output logic [W-1:0]     wb_data,
  output logic             irq_restore,
  output logic             err_over,
  output logic             err_under
);

  localparam int PTR_W = $clog2(DEPTH + 1);

  // internal events, named for the checker
  logic             push_go, pop_go, over_evt, under_evt;
  logic             stk_full, stk_empty;
  logic [PTR_W-1:0] stk_depth;
  logic [W-1:0]     top_data, link_pc, push_data;
  push_sel_e        push_src;
  pc_sel_e          pc_src;

  pcflow_decode u_dec (
    .cond_ok     (cond_ok),
    .cls         (op_class_e'(op_cls)),
    .kind        (op_kind),
    .stk_full    (stk_full),
    .stk_empty   (stk_empty),
    .push_go     (push_go),
    .push_src    (push_src),
    .pop_go      (pop_go),
    .wb_en       (wb_en),
    .pc_src      (pc_src),
    .irq_restore (irq_restore),
    .over_evt    (over_evt),
    .under_evt   (under_evt)
  );

  pcflow_target #(.W(W), .OFF_W(OFF_W), .STEP(STEP)) u_tgt (
    .pc_src   (pc_src),
    .pc_cur   (pc_cur),
    .off_neg  (off_neg),
    .off_mag  (off_mag),
    .reg_val  (reg_val),
    .top_data (top_data),
    .link_pc  (link_pc),
    .pc_next  (pc_next)
  );

  always_comb begin
    unique case (push_src)
      PS_HERE: push_data = pc_cur;
      PS_REG:  push_data = reg_val;
      default: push_data = link_pc;
    endcase
  end

  pcflow_retstack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_go   (push_go),
    .pop_go    (pop_go),
    .push_data (push_data),
    .top_data  (top_data),
    .full      (stk_full),
    .empty     (stk_empty),
    .depth     (stk_depth)
  );

  assign wb_data = wb_en ? top_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_over  <= 1'b0;
      err_under <= 1'b0;
    end else begin
      if (over_evt)  err_over  <= 1'b1;
      if (under_evt) err_under <= 1'b1;
    end
  end

endmodule

// File: rtl/pcflow_unit_chk.sv
module pcflow_unit_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int STEP  = 4,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cond_ok,
  input logic [W-1:0]     pc_cur,
  input logic [W-1:0]     pc_next,
  input logic             wb_en,
  input logic             irq_restore,
  input logic             err_over,
  input logic             err_under,
  input logic             over_evt,
  input logic             under_evt,
  input logic             push_go,
  input logic             pop_go,
  input logic [PTR_W-1:0] stk_depth
);

  p_hold_on_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |-> (pc_next == pc_cur + W'(STEP)) && !wb_en && !irq_restore);

  p_depth_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> stk_depth == $past(stk_depth));

  p_push_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> stk_depth == PTR_W'($past(stk_depth) + 1'b1));

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> stk_depth == PTR_W'($past(stk_depth) - 1'b1));

  p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= PTR_W'(DEPTH));

  p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_go && pop_go));

  p_over_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt |=> err_over && stk_depth == $past(stk_depth));

  p_under_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> err_under && stk_depth == $past(stk_depth));

  p_under_falls_through_r12: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |-> pc_next == pc_cur + W'(STEP) && !wb_en && !irq_restore);

  p_over_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_over |=> err_over);

  p_under_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_under |=> err_under);

endmodule

bind pcflow_unit pcflow_unit_chk #(
  .W(W), .DEPTH(DEPTH), .STEP(STEP), .PTR_W(PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cond_ok     (cond_ok),
  .pc_cur      (pc_cur),
  .pc_next     (pc_next),
  .wb_en       (wb_en),
  .irq_restore (irq_restore),
  .err_over    (err_over),
  .err_under   (err_under),
  .over_evt    (over_evt),
  .under_evt   (under_evt),
  .push_go     (push_go),
  .pop_go      (pop_go),
  .stk_depth   (stk_depth)
);

// File: tb/pcflow_unit_tb.sv
module pcflow_unit_tb;

  localparam int CLK_P = 10;
  localparam int DEP   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cond_ok = 1'b1;
  logic [1:0]  op_cls = 2'b00;
  logic [1:0]  op_kind = 2'b00;
  logic        off_neg = 1'b0;
  logic [15:0] off_mag = '0;
  logic [31:0] reg_val = '0;
  logic [31:0] pc_cur = '0;
  logic [31:0] pc_next, wb_data;
  logic        wb_en, irq_restore, err_over, err_under;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pcflow_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cond_ok(cond_ok), .op_cls(op_cls),
    .op_kind(op_kind), .off_neg(off_neg), .off_mag(off_mag),
    .reg_val(reg_val), .pc_cur(pc_cur), .pc_next(pc_next),
    .wb_en(wb_en), .wb_data(wb_data), .irq_restore(irq_restore),
    .err_over(err_over), .err_under(err_under)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change after the falling edge; outputs are sampled 1 time unit later
  task automatic step(input logic [1:0] c, input logic [1:0] k, input logic ok,
                      input logic ng, input logic [15:0] m,
                      input logic [31:0] r, input logic [31:0] pc);
    @(negedge clk);
    op_cls = c; op_kind = k; cond_ok = ok; off_neg = ng; off_mag = m;
    reg_val = r; pc_cur = pc;
    #1;
  endtask

  task automatic idle();
    step(2'b00, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
  endtask

  task automatic push(input logic [31:0] v);
    step(2'b11, 2'b11, 1'b1, 1'b0, 16'h0, v, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_cls = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    idle();
    chk("R1 err_over after reset", {31'b0, err_over}, 32'h0);
    chk("R1 err_under after reset", {31'b0, err_under}, 32'h0);
  endtask

  task automatic t_seq();
    step(2'b00, 2'b11, 1'b1, 1'b1, 16'h1234, 32'h55, 32'h0000_1000);
    chk("R13 sequential pc", pc_next, 32'h0000_1004);
    chk("R13 no write-back", {31'b0, wb_en}, 32'h0);
    step(2'b00, 2'b01, 1'b1, 1'b0, 16'h0, 32'h0, 32'hFFFF_FFFC);
    chk("R13 sequential wrap", pc_next, 32'h0);
  endtask

  task automatic t_rel();
    step(2'b01, 2'b00, 1'b1, 1'b0, 16'h0120, 32'h0, 32'h0000_2000);
    chk("R3 forward jump", pc_next, 32'h0000_2120);
    step(2'b01, 2'b00, 1'b1, 1'b1, 16'h0120, 32'h0, 32'h0000_2000);
    chk("R3 backward jump", pc_next, 32'h0000_1EE0);
    step(2'b01, 2'b00, 1'b1, 1'b1, 16'h0020, 32'h0, 32'h0000_0010);
    chk("R3 backward wrap", pc_next, 32'hFFFF_FFF0);
    step(2'b01, 2'b00, 1'b1, 1'b0, 16'hFFFF, 32'h0, 32'hFFFF_0004);
    chk("R3 forward wrap", pc_next, 32'h0000_0003);
  endtask

  task automatic t_call_ret();
    step(2'b01, 2'b01, 1'b1, 1'b0, 16'h0040, 32'h0, 32'h0000_0100);
    chk("R4 call target", pc_next, 32'h0000_0140);
    step(2'b01, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0500);
    chk("R5 return to link", pc_next, 32'h0000_0104);
    chk("R5 return no irq", {31'b0, irq_restore}, 32'h0);
    step(2'b01, 2'b01, 1'b1, 1'b1, 16'h0080, 32'h0, 32'h0000_0200);
    chk("R4 backward call target", pc_next, 32'h0000_0180);
    step(2'b01, 2'b11, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0900);
    chk("R5 reti to link", pc_next, 32'h0000_0204);
    chk("R5 reti restores irq", {31'b0, irq_restore}, 32'h1);
    idle();
    chk("R5 irq pulse one cycle", {31'b0, irq_restore}, 32'h0);
  endtask

  task automatic t_ind();
    push(32'h0000_AAAA);
    step(2'b10, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0000_8000, 32'h0000_0300);
    chk("R6 indirect jump", pc_next, 32'h0000_8000);
    step(2'b11, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0310);
    chk("R6 plain indirect pushes nothing", wb_data, 32'h0000_AAAA);
    step(2'b10, 2'b01, 1'b1, 1'b0, 16'h0, 32'h0000_9000, 32'h0000_0340);
    chk("R6 indirect call", pc_next, 32'h0000_9000);
    step(2'b11, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0400);
    chk("R6 indirect call pushed pc", wb_data, 32'h0000_0340);
    step(2'b11, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0404);
    chk("R7 pop older entry", wb_data, 32'h0000_AAAA);
  endtask

  task automatic t_cond_fail();
    push(32'h0000_0011);
    step(2'b01, 2'b01, 1'b0, 1'b0, 16'h0100, 32'h0, 32'h0000_0600);
    chk("R2 skipped call pc", pc_next, 32'h0000_0604);
    step(2'b01, 2'b11, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0000_0700);
    chk("R2 skipped reti pc", pc_next, 32'h0000_0704);
    chk("R2 skipped reti irq", {31'b0, irq_restore}, 32'h0);
    step(2'b11, 2'b00, 1'b0, 1'b0, 16'h0, 32'h0, 32'h0000_0708);
    chk("R2 skipped pop wb", {31'b0, wb_en}, 32'h0);
    step(2'b11, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_070C);
    chk("R2 stack untouched", wb_data, 32'h0000_0011);
    step(2'b11, 2'b01, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
  endtask

  task automatic t_stack();
    push(32'h0000_00A1);
    push(32'h0000_00B2);
    step(2'b11, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0800);
    chk("R9 fetch value", wb_data, 32'h0000_00B2);
    chk("R9 fetch wb_en", {31'b0, wb_en}, 32'h1);
    chk("R7 stack op pc", pc_next, 32'h0000_0804);
    step(2'b11, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
    chk("R9 fetch keeps depth", wb_data, 32'h0000_00B2);
    step(2'b11, 2'b01, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
    chk("R8 discard no wb", {31'b0, wb_en}, 32'h0);
    step(2'b11, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
    chk("R8 discard removed top", wb_data, 32'h0000_00A1);
    chk("R7 pop wb_en", {31'b0, wb_en}, 32'h1);
    idle();
    chk("R10 no error from normal use", {30'b0, err_over, err_under}, 32'h0);
  endtask

  task automatic t_full_empty();
    for (int i = 0; i < DEP; i++) push(32'h0000_1000 + i);
    push(32'h0000_DEAD);
    idle();
    chk("R12 overflow flag", {31'b0, err_over}, 32'h1);
    chk("R12 no underflow yet", {31'b0, err_under}, 32'h0);
    for (int i = 0; i < DEP; i++) begin
      step(2'b11, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
      chk("R11 LIFO order", wb_data, 32'h0000_1000 + DEP - 1 - i);
    end
    step(2'b11, 2'b00, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0A00);
    chk("R12 empty pop no wb", {31'b0, wb_en}, 32'h0);
    step(2'b01, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0040);
    chk("R12 empty return falls through", pc_next, 32'h0000_0044);
    step(2'b01, 2'b11, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0000_0050);
    chk("R12 empty reti falls through", pc_next, 32'h0000_0054);
    chk("R12 empty reti no irq", {31'b0, irq_restore}, 32'h0);
    idle();
    chk("R12 underflow flag", {31'b0, err_under}, 32'h1);
    chk("R12 overflow sticky", {31'b0, err_over}, 32'h1);
    do_reset();
    t_reset();
    step(2'b11, 2'b10, 1'b1, 1'b0, 16'h0, 32'h0, 32'h0);
    chk("R1 empty after reset", {31'b0, wb_en}, 32'h0);
    idle();
    chk("R1 empty fetch underflows", {31'b0, err_under}, 32'h1);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_seq();
    t_rel();
    t_call_ret();
    t_ind();
    t_cond_fail();
    t_stack();
    t_full_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule